// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a synchronous request port to an external byte-wide asynchronous static RAM with a 19-bit address and one shared 8-bit data bus. A client offers one request at a time with a valid/ready handshake. Each request is a read or a write, with an address and, for writes, a data byte. The controller runs the memory-side sequence as a series of whole clock cycles and returns read bytes with a one-cycle valid strobe.

Every memory-side output is registered. Each one is decoded from the next sequencer state, so no strobe can glitch. Three parameters set the cycle counts, and they are chosen from the clock period so that the memory's minimum timings hold: the length of the write-enable pulse, the number of cycles the read is held before the data is sampled, and the number of quiet cycles the controller waits before it drives the bus after a read.

During a write, output enable stays high for the whole access, which allows the shorter write pulse. The controller drives the data bus only inside the write sequence, and only after the memory has had time to release the bus following the last read.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, mem_cs_n, mem_we_n and mem_oe_n are all 1, mem_dq_oe is 0, rd_valid is 0 and req_ready is 1.
- R2: req_ready is 1 exactly when the sequencer is idle. A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from the cycle after that edge until the memory-side sequence is idle again, and mem_cs_n is never 0 while req_ready is 1.
- R3: A read (req_write = 0) presents the request address on mem_addr and holds mem_cs_n = 0, mem_oe_n = 0 and mem_we_n = 1 for exactly RD_ACCESS_CYC cycles. These cycles start in the cycle after acceptance.
- R4: On the clock edge that ends the read window, the value on mem_dq_in is captured into rd_data. In the following cycle mem_oe_n and mem_cs_n are 1, rd_valid is 1 for exactly that one cycle, and req_ready is 1.
- R5: A write (req_write = 1) with no turnaround pending runs four phases. First, one cycle with mem_cs_n = 0, mem_we_n = 1 and the data driven. Then mem_we_n = 0 for exactly WR_PULSE_CYC cycles. Then one hold cycle with mem_we_n = 1, mem_cs_n = 0 and the data still driven. In the cycle after that, all strobes are released and mem_dq_oe is 0. mem_we_n is never 0 while mem_cs_n is 1.
- R6: mem_oe_n is 1 in every cycle in which mem_we_n is 0.
- R7: mem_addr and mem_dq_out do not change between consecutive cycles in which mem_we_n is 0.
- R8: mem_dq_oe is 1 only while mem_cs_n is 0 and mem_oe_n is 1.
- R9: After a read, mem_dq_oe does not rise until mem_oe_n has been 1 for at least TURN_CYC cycles. If a write is accepted in the first cycle after a read, mem_dq_oe first rises exactly TURN_CYC cycles after mem_oe_n rose.
- R10: Changes on req_addr, req_wdata and req_write while req_ready is 0 have no effect. mem_addr, mem_dq_out and the sequence under way stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_in | input | 8 | Data from the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus when 1 |

## Verification
The assertions check the strobe relations on every cycle. They cover output enable being high whenever write enable is low, write enable needing chip select, the bus driver being on only in a selected non-read cycle, address and data staying frozen across the write pulse, the read strobe lasting one cycle, and a quiet-cycle counter that must reach TURN_CYC before the driver turns on. Only the bench scenarios can show the exact phase lengths of reads and writes and that the captured byte matches what was written. They also show the exact turnaround gap when a write follows a read at once, and that request fields changed while busy leave the sequence under way untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_WR_TURN  = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } mem_ctl_t;

    localparam mem_ctl_t CTL_RELEASED = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    // Strobe levels owned by each sequencer state.
    function automatic mem_ctl_t ctl_for_state(input seq_state_e s);
        mem_ctl_t c;
        c = CTL_RELEASED;
        case (s)
            ST_RD_ACC: begin
                c.cs_n = 1'b0;
                c.oe_n = 1'b0;
            end
            ST_WR_SETUP, ST_WR_HOLD: begin
                c.cs_n  = 1'b0;
                c.dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                c.cs_n  = 1'b0;
                c.we_n  = 1'b0;
                c.dq_oe = 1'b1;
            end
            default: c = CTL_RELEASED;
        endcase
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int WR_PULSE_CYC  = 2,
    parameter int RD_ACCESS_CYC = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  logic     req_write,
    input  logic     turn_clear,
    output logic     req_ready,
    output logic     accept,
    output logic     rd_done,
    output mem_ctl_t ctl_next
);
    localparam int MAXC = max2(WR_PULSE_CYC, RD_ACCESS_CYC);
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

    seq_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        rd_done = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        state_d = turn_clear ? ST_WR_SETUP : ST_WR_TURN;
                    end else begin
                        state_d = ST_RD_ACC;
                        cnt_d   = CW'(RD_ACCESS_CYC - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (cnt_q == '0) begin
                    rd_done = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WR_TURN: begin
                if (turn_clear) state_d = ST_WR_SETUP;
            end
            ST_WR_SETUP: begin
                state_d = ST_WR_PULSE;
                cnt_d   = CW'(WR_PULSE_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (cnt_q == '0) state_d = ST_WR_HOLD;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_WR_HOLD: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign ctl_next  = ctl_for_state(state_d);

    // R9: the bus driver phase is only entered once turnaround is clear
    a_r9_setup_needs_clear: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WR_TURN && state_d == ST_WR_SETUP) |-> turn_clear);

    // R5: a pulse phase is always preceded by the setup phase
    a_r5_pulse_after_setup: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WR_PULSE && $past(state_q) != ST_WR_PULSE) |-> $past(state_q) == ST_WR_SETUP);

endmodule

// File: rtl/sram_ctrl_turn.sv
module sram_ctrl_turn #(
    parameter int TURN_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic oe_release,
    output logic turn_clear
);
    localparam int TW = (TURN_CYC < 2) ? 1 : $clog2(TURN_CYC);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (oe_release) begin
            left_q <= TW'(TURN_CYC - 1);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign turn_clear = (left_q == '0);

    // R9: a fresh release always arms the wait for TURN_CYC above one
    a_r9_armed_after_release: assert property (@(posedge clk) disable iff (rst)
        (oe_release && TURN_CYC > 1) |=> !turn_clear);

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int TURN_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  mem_ctl_t          ctl_next,
    input  logic              accept,
    input  logic              rd_done,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    localparam int QW = $clog2(TURN_CYC + 1);

    mem_ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= CTL_RELEASED;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            rd_data    <= '0;
            rd_valid   <= 1'b0;
        end else begin
            ctl_q    <= ctl_next;
            rd_valid <= rd_done;
            if (accept) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
            end
            if (rd_done) rd_data <= mem_dq_in;
        end
    end

    assign mem_cs_n  = ctl_q.cs_n;
    assign mem_we_n  = ctl_q.we_n;
    assign mem_oe_n  = ctl_q.oe_n;
    assign mem_dq_oe = ctl_q.dq_oe;

    // Checker state: quiet cycles since output enable was last low.
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk) begin
        if (rst)                     quiet_q <= QW'(TURN_CYC);
        else if (!ctl_q.oe_n)        quiet_q <= '0;
        else if (quiet_q < QW'(TURN_CYC)) quiet_q <= quiet_q + 1'b1;
    end

    // R6: output enable stays high during the write pulse
    a_r6_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    // R5: write enable only inside a selected cycle
    a_r5_we_needs_cs: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);

    // R8: bus driver only in a selected, non-read cycle
    a_r8_drive_no_contention: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (mem_oe_n && !mem_cs_n));

    // R7: address and data frozen across the write pulse
    a_r7_stable_in_pulse: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R4: read strobe lasts one cycle
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R9: driver turns on only after enough quiet cycles
    a_r9_turnaround_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (quiet_q >= QW'(TURN_CYC)));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int WR_PULSE_CYC  = 2,
    parameter int RD_ACCESS_CYC = 3,
    parameter int TURN_CYC      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    mem_ctl_t ctl_next;
    logic     accept;
    logic     rd_done;
    logic     turn_clear;

    sram_ctrl_seq #(
        .WR_PULSE_CYC (WR_PULSE_CYC),
        .RD_ACCESS_CYC(RD_ACCESS_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .turn_clear(turn_clear),
        .req_ready (req_ready),
        .accept    (accept),
        .rd_done   (rd_done),
        .ctl_next  (ctl_next)
    );

    sram_ctrl_turn #(
        .TURN_CYC(TURN_CYC)
    ) u_turn (
        .clk       (clk),
        .rst       (rst),
        .oe_release(rd_done),
        .turn_clear(turn_clear)
    );

    sram_ctrl_pins #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .TURN_CYC(TURN_CYC)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .ctl_next  (ctl_next),
        .accept    (accept),
        .rd_done   (rd_done),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_in (mem_dq_in),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .mem_cs_n  (mem_cs_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_addr  (mem_addr),
        .mem_dq_out(mem_dq_out),
        .mem_dq_oe (mem_dq_oe)
    );

    // R2: the memory is never selected while a new request may be taken
    a_r2_busy_while_selected: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> !req_ready);

    // R2: a taken request always makes the block busy next cycle
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
    localparam int AW = 19;
    localparam int DW = 8;
    localparam int WP = 2;
    localparam int RA = 3;
    localparam int TC = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW),
        .WR_PULSE_CYC(WP), .RD_ACCESS_CYC(RA), .TURN_CYC(TC)
    ) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // Small memory model indexed by the low address bits
    logic [DW-1:0] model [16];
    initial for (int i = 0; i < 16; i++) model[i] = '0;
    always @(posedge clk)
        if (!mem_cs_n && !mem_we_n) model[mem_addr[3:0]] <= mem_dq_out;
    assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ? model[mem_addr[3:0]] : 8'h00;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive a request at a negedge, let it be taken, return at the next negedge (k=1)
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        chk("R2 ready before issue", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 cs in reset", 32'(mem_cs_n), 1);
        chk("R1 dq_oe in reset", 32'(mem_dq_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 strobes after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        chk("R1 ready/valid after reset", {req_ready, rd_valid}, 2'b10);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        issue(1'b1, a, d);
        // k=1 setup phase; junk on request fields must be ignored (R10)
        req_addr = ~a; req_wdata = ~d; req_write = 1'b0;
        chk("R5 setup strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0111);
        chk("R5 setup addr", 32'(mem_addr), 32'(a));
        chk("R5 setup data", 32'(mem_dq_out), 32'(d));
        chk("R2 busy in setup", 32'(req_ready), 0);
        for (int k = 0; k < WP; k++) begin
            @(negedge clk);
            chk("R5 pulse we low", 32'(mem_we_n), 0);
            chk("R6 oe high in pulse", 32'(mem_oe_n), 1);
            chk("R10 addr unchanged", 32'(mem_addr), 32'(a));
            chk("R7 data unchanged", 32'(mem_dq_out), 32'(d));
        end
        @(negedge clk);
        chk("R5 hold strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0111);
        @(negedge clk);
        chk("R5 released", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        chk("R2 ready after write", 32'(req_ready), 1);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        issue(1'b0, a, 8'h00);
        for (int k = 1; k <= RA; k++) begin
            if (k > 1) @(negedge clk);
            chk("R3 read strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0100);
            chk("R3 read addr", 32'(mem_addr), 32'(a));
            chk("R4 no early valid", 32'(rd_valid), 0);
        end
        @(negedge clk);
        chk("R4 valid strobe", 32'(rd_valid), 1);
        chk("R4 read data", 32'(rd_data), 32'(exp));
        chk("R4 released after read", {mem_cs_n, mem_oe_n, req_ready}, 3'b111);
        @(negedge clk);
        chk("R4 strobe one cycle", 32'(rd_valid), 0);
        chk("R4 data held", 32'(rd_data), 32'(exp));
    endtask

    // Read followed at once by a write: exact turnaround gap
    task automatic t_turnaround(input logic [AW-1:0] ra, input logic [DW-1:0] rexp,
                                input logic [AW-1:0] wa, input logic [DW-1:0] wd);
        int gap;
        issue(1'b0, ra, 8'h00);
        repeat (RA) @(negedge clk);
        chk("R4 turnaround read data", 32'(rd_data), 32'(rexp));
        req_valid = 1'b1; req_write = 1'b1; req_addr = wa; req_wdata = wd;
        gap = 0;
        for (int g = 0; g < 20; g++) begin
            @(negedge clk);
            req_valid = 1'b0;
            gap++;
            if (mem_dq_oe) break;
            chk("R8 no drive during turnaround", 32'(mem_dq_oe), 0);
        end
        chk("R9 turnaround gap", 32'(gap), 32'(TC));
        chk("R9 oe high at drive", 32'(mem_oe_n), 1);
        repeat (WP + 2) @(negedge clk);
        chk("R2 idle after turnaround write", 32'(req_ready), 1);
    endtask

    // Valid held high: second read only taken after the first completes
    task automatic t_back_to_back(input logic [AW-1:0] a1, input logic [DW-1:0] e1,
                                  input logic [AW-1:0] a2, input logic [DW-1:0] e2);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a1;
        @(negedge clk);
        req_addr = a2;
        for (int k = 1; k <= RA; k++) begin
            if (k > 1) @(negedge clk);
            chk("R2 ready low while busy", 32'(req_ready), 0);
            chk("R10 first addr kept", 32'(mem_addr), 32'(a1));
        end
        @(negedge clk);
        chk("R4 first valid", 32'(rd_valid), 1);
        chk("R4 first data", 32'(rd_data), 32'(e1));
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 second accepted at idle", 32'(mem_addr), 32'(a2));
        chk("R3 second read selected", {mem_cs_n, mem_oe_n}, 2'b00);
        repeat (RA) @(negedge clk);
        chk("R4 second valid", 32'(rd_valid), 1);
        chk("R4 second data", 32'(rd_data), 32'(e2));
    endtask

    initial begin
        t_reset();
        t_write(19'h00003, 8'h5A);
        t_write(19'h7FFF5, 8'hC3);
        t_read(19'h00003, 8'h5A);
        t_read(19'h7FFF5, 8'hC3);
        t_turnaround(19'h00003, 8'h5A, 19'h1234A, 8'h96);
        t_read(19'h1234A, 8'h96);
        t_back_to_back(19'h7FFF5, 8'hC3, 19'h1234A, 8'h96);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule